// File: doc/BRIEF.md
# Buck Converter Start-up and Fault Supervisor

This block runs the digital side of a single-phase step-down controller. It waits for the bias supply to come up after a real dip, then raises a reference code from zero to the full setpoint in small steps. It watches sampled comparator flags for over-current, short-circuit, over-voltage, under-voltage and over-temperature. When a latching fault appears, it stops switching and reports the fault class as a two-bit pull-down strength code for the power-good pin.

All timing counts a free-running 1 MHz strobe, `tick_i`. Current samples arrive once per switching pulse on `pulse_i`. An over-voltage trip leaves the low-side switch forced on as a crowbar, with hysteresis between the trip flag and the release flag. Over-temperature only holds off switching. Every latched fault stays until enable drops or the bias supply falls below its lower reset threshold.

Top module: `buck_fault_supervisor`

## Requirements
- R1: After reset with enable low, `pwm_en_o`=0, `ss_ref_o`=0, `lg_force_o`=0 and `pg_code_o`=0 (open).
- R2: A start needs an arm. Reset sets the arm, and so does `vcc_low_i` high. A start clears it. Raising enable again with no arm leaves `pwm_en_o`=0 and `ss_ref_o`=0.
- R3: After a start, `ss_ref_o` starts at 0. It rises by one every STEP_TICKS ticks (5) until it reaches REF_FULL (300, so 1500 ticks), and `pwm_en_o` is 1 during the ramp.
- R4: Code values are 0 = open, 1 = weak, 2 = medium and 3 = strong. The code is 1 while enable is high and the output has not yet been released. It becomes 0 on the tick that completes PG_TICKS (2750) ticks after the start, provided no fault is latched.
- R5: An over-current fault latches, giving code 3, on the OC_TICKS-th (20th) tick of an unbroken run of over-limit pulses. A pulse sampled below the limit restarts the run from zero.
- R6: A short-circuit fault latches, giving code 3, when a short-circuit pulse follows another one with fewer than SC_TICKS (10) ticks between them. A gap of 10 or more does not latch.
- R7: Over-voltage while running latches the fault, giving code 2, and sets `lg_force_o`. `fb_ovrel_i` clears `lg_force_o`, and each new `fb_ov_i` sets it again.
- R8: Under-voltage latches the fault, giving code 1, only in regulation after the ramp has finished. It is ignored during the ramp.
- R9: Over-temperature (`ot_hot_i`) clears `pwm_en_o` without latching and without changing `pg_code_o`. `ot_cool_i` restores switching.
- R10: Latched faults persist through ticks and pulses. Enable low or `vcc_low_i` clears them. Enable low forces `pwm_en_o`=0 and code 0 in the same cycle.
- R11: When faults latch in the same cycle, the code follows the order over-current (3), then over-voltage (2), then under-voltage (1).
- R12: A latched fault clears `pwm_en_o` from the next cycle on. `lg_force_o` stays 0 for faults other than over-voltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable |
| vcc_ok_i | input | 1 | Bias supply above its rising threshold |
| vcc_low_i | input | 1 | Bias supply below its falling threshold |
| tick_i | input | 1 | 1 MHz time strobe, one cycle wide |
| pulse_i | input | 1 | Strobe marking one switching-pulse current sample |
| oc_i | input | 1 | Current sample above the over-current limit |
| sc_i | input | 1 | Current sample above the short-circuit limit |
| fb_ov_i | input | 1 | Feedback above the over-voltage trip level |
| fb_ovrel_i | input | 1 | Feedback below the crowbar release level |
| fb_uv_i | input | 1 | Feedback below the under-voltage level |
| ot_hot_i | input | 1 | Die temperature above its trip point |
| ot_cool_i | input | 1 | Die temperature back below trip minus hysteresis |
| ss_ref_o | output | REF_W | Soft-start reference code |
| pwm_en_o | output | 1 | Switching allowed |
| lg_force_o | output | 1 | Force the low-side switch on |
| pg_code_o | output | 2 | Power-good pull-down strength code |

## Verification
Over-current qualification and the feedback comparators can both fire on the same clock. The tests provoke this by bringing an over-current run to one tick before its limit. They then drive that final tick together with the over-voltage and under-voltage flags. The check is that the code reads 3 afterwards. A second run raises over-voltage and under-voltage together and expects code 2.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

   typedef enum logic [1:0] {
      PG_OPEN   = 2'b00,
      PG_WEAK   = 2'b01,
      PG_MED    = 2'b10,
      PG_STRONG = 2'b11
   } pg_code_e;

   typedef enum logic [1:0] {
      ST_OFF  = 2'b00,
      ST_RAMP = 2'b01,
      ST_REG  = 2'b10,
      ST_TRIP = 2'b11
   } sup_state_e;

endpackage

// File: rtl/bfs_softstart.sv
module bfs_softstart #(
   parameter int REF_W      = 10,
   parameter int REF_FULL   = 300,
   parameter int STEP_TICKS = 5,
   parameter int PG_TICKS   = 2750
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             run_i,
   input  logic             tick_i,
   output logic [REF_W-1:0] ref_o,
   output logic             ramp_done_o,
   output logic             pg_time_o
);
   localparam int PG_W = $clog2(PG_TICKS + 1);
   localparam logic [REF_W-1:0] FULL_C = REF_W'(REF_FULL);
   localparam logic [PG_W-1:0]  PG_C   = PG_W'(PG_TICKS);

   if (REF_FULL < 1 || REF_FULL >= (1 << REF_W)) begin : g_bad_ref
      $error("bfs_softstart: REF_FULL does not fit REF_W");
   end
   if (STEP_TICKS < 1 || PG_TICKS < 1) begin : g_bad_time
      $error("bfs_softstart: tick counts must be positive");
   end

   logic [REF_W-1:0] ref_q;
   logic [PG_W-1:0]  pg_cnt_q;
   logic             step_now;

   assign ramp_done_o = (ref_q == FULL_C);
   assign pg_time_o   = (pg_cnt_q == PG_C);
   assign ref_o       = ref_q;

   if (STEP_TICKS == 1) begin : g_step_direct
      assign step_now = run_i && tick_i;
   end else begin : g_step_div
      localparam int STEP_W = $clog2(STEP_TICKS);
      localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_TICKS - 1);
      logic [STEP_W-1:0] div_q;
      assign step_now = run_i && tick_i && (div_q == STEP_LAST);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q <= '0;
         end else if (clear_i || ramp_done_o) begin
            div_q <= '0;
         end else if (run_i && tick_i) begin
            div_q <= (div_q == STEP_LAST) ? '0 : div_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q    <= '0;
         pg_cnt_q <= '0;
      end else if (clear_i) begin
         ref_q    <= '0;
         pg_cnt_q <= '0;
      end else begin
         if (step_now && !ramp_done_o) begin
            ref_q <= ref_q + 1'b1;
         end
         if (run_i && tick_i && !pg_time_o) begin
            pg_cnt_q <= pg_cnt_q + 1'b1;
         end
      end
   end

   // R3: the reference only climbs in unit steps or returns to zero
   assert_ramp_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_q != $past(ref_q)) |-> ((ref_q == REF_W'($past(ref_q) + 1)) || (ref_q == '0)));

endmodule

// File: rtl/bfs_oc_qual.sv
module bfs_oc_qual #(
   parameter int OC_TICKS = 20,
   parameter int SC_TICKS = 10,
   parameter bit SC_EN    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic pulse_i,
   input  logic tick_i,
   input  logic oc_i,
   input  logic sc_i,
   output logic oc_trip_o,
   output logic sc_trip_o
);
   localparam int OC_W = $clog2(OC_TICKS);
   localparam logic [OC_W-1:0] OC_LAST = OC_W'(OC_TICKS - 1);

   if (OC_TICKS < 2) begin : g_bad_oc
      $error("bfs_oc_qual: OC_TICKS must be at least 2");
   end

   logic            run_q;
   logic [OC_W-1:0] run_cnt_q;

   assign oc_trip_o = tick_i && run_q && (run_cnt_q == OC_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         run_cnt_q <= '0;
      end else if (clear_i) begin
         run_q     <= 1'b0;
         run_cnt_q <= '0;
      end else if (pulse_i && !oc_i) begin
         run_q     <= 1'b0;
         run_cnt_q <= '0;
      end else if (pulse_i && oc_i && !run_q) begin
         run_q     <= 1'b1;
         run_cnt_q <= '0;
      end else if (tick_i && run_q && run_cnt_q != OC_LAST) begin
         run_cnt_q <= run_cnt_q + 1'b1;
      end
   end

   if (SC_EN) begin : g_sc
      localparam int SC_W = $clog2(SC_TICKS + 1);
      localparam logic [SC_W-1:0] SC_LIM = SC_W'(SC_TICKS);
      logic            sc_arm_q;
      logic [SC_W-1:0] sc_gap_q;

      assign sc_trip_o = pulse_i && sc_i && sc_arm_q && (sc_gap_q < SC_LIM);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sc_arm_q <= 1'b0;
            sc_gap_q <= '0;
         end else if (clear_i) begin
            sc_arm_q <= 1'b0;
            sc_gap_q <= '0;
         end else if (pulse_i) begin
            sc_arm_q <= sc_i;
            sc_gap_q <= '0;
         end else if (tick_i && sc_arm_q && sc_gap_q < SC_LIM) begin
            sc_gap_q <= sc_gap_q + 1'b1;
         end
      end
   end else begin : g_no_sc
      assign sc_trip_o = 1'b0;
   end

   // R5: a below-limit sample leaves no room for a trip on the next cycle
   assert_oc_run_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_i && !oc_i) |=> !oc_trip_o);

endmodule

// File: rtl/bfs_pg_encode.sv
module bfs_pg_encode
   import bfs_pkg::*;
(
   input  logic     en_i,
   input  logic     flt_oc_i,
   input  logic     flt_ov_i,
   input  logic     flt_uv_i,
   input  logic     released_i,
   output pg_code_e code_o
);
   always_comb begin
      if (!en_i)            code_o = PG_OPEN;
      else if (flt_oc_i)    code_o = PG_STRONG;
      else if (flt_ov_i)    code_o = PG_MED;
      else if (flt_uv_i)    code_o = PG_WEAK;
      else if (!released_i) code_o = PG_WEAK;
      else                  code_o = PG_OPEN;
   end
endmodule

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor
   import bfs_pkg::*;
#(
   parameter int REF_W      = 10,
   parameter int REF_FULL   = 300,
   parameter int STEP_TICKS = 5,
   parameter int PG_TICKS   = 2750,
   parameter int OC_TICKS   = 20,
   parameter int SC_TICKS   = 10,
   parameter bit SC_EN      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             vcc_ok_i,
   input  logic             vcc_low_i,
   input  logic             tick_i,
   input  logic             pulse_i,
   input  logic             oc_i,
   input  logic             sc_i,
   input  logic             fb_ov_i,
   input  logic             fb_ovrel_i,
   input  logic             fb_uv_i,
   input  logic             ot_hot_i,
   input  logic             ot_cool_i,
   output logic [REF_W-1:0] ss_ref_o,
   output logic             pwm_en_o,
   output logic             lg_force_o,
   output logic [1:0]       pg_code_o
);
   sup_state_e state_q;
   logic       armed_q, ot_hold_q, crowbar_q;
   logic       flt_oc_q, flt_ov_q, flt_uv_q;
   logic       clr, start, monitor;
   logic       oc_trip, sc_trip, oc_hit, ov_hit, uv_hit, any_hit;
   logic       ramp_done, pg_time;
   pg_code_e   pg_code;

   assign clr     = !en_i || vcc_low_i;
   assign start   = (state_q == ST_OFF) && !clr && vcc_ok_i && armed_q;
   assign monitor = (state_q == ST_RAMP) || (state_q == ST_REG);
   assign oc_hit  = oc_trip || sc_trip;
   assign ov_hit  = monitor && fb_ov_i;
   assign uv_hit  = (state_q == ST_REG) && fb_uv_i;
   assign any_hit = oc_hit || ov_hit || uv_hit;

   bfs_softstart #(
      .REF_W(REF_W), .REF_FULL(REF_FULL),
      .STEP_TICKS(STEP_TICKS), .PG_TICKS(PG_TICKS)
   ) u_ramp (
      .clk(clk), .rst_n(rst_n), .clear_i(state_q == ST_OFF),
      .run_i(monitor), .tick_i(tick_i),
      .ref_o(ss_ref_o), .ramp_done_o(ramp_done), .pg_time_o(pg_time)
   );

   bfs_oc_qual #(
      .OC_TICKS(OC_TICKS), .SC_TICKS(SC_TICKS), .SC_EN(SC_EN)
   ) u_ocq (
      .clk(clk), .rst_n(rst_n), .clear_i(!monitor),
      .pulse_i(pulse_i), .tick_i(tick_i), .oc_i(oc_i), .sc_i(sc_i),
      .oc_trip_o(oc_trip), .sc_trip_o(sc_trip)
   );

   bfs_pg_encode u_pg (
      .en_i(en_i), .flt_oc_i(flt_oc_q), .flt_ov_i(flt_ov_q), .flt_uv_i(flt_uv_q),
      .released_i(pg_time && (state_q == ST_REG)), .code_o(pg_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OFF;
      end else if (clr) begin
         state_q <= ST_OFF;
      end else begin
         unique case (state_q)
            ST_OFF:  if (start) state_q <= ST_RAMP;
            ST_RAMP: if (any_hit) state_q <= ST_TRIP;
                     else if (ramp_done) state_q <= ST_REG;
            ST_REG:  if (any_hit) state_q <= ST_TRIP;
            default: state_q <= ST_TRIP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_oc_q <= 1'b0;
         flt_ov_q <= 1'b0;
         flt_uv_q <= 1'b0;
      end else if (clr) begin
         flt_oc_q <= 1'b0;
         flt_ov_q <= 1'b0;
         flt_uv_q <= 1'b0;
      end else begin
         flt_oc_q <= flt_oc_q || oc_hit;
         flt_ov_q <= flt_ov_q || ov_hit;
         flt_uv_q <= flt_uv_q || uv_hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
      end else if (vcc_low_i) begin
         armed_q <= 1'b1;
      end else if (start) begin
         armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ot_hold_q <= 1'b0;
      end else if (clr || ot_cool_i) begin
         ot_hold_q <= 1'b0;
      end else if (ot_hot_i) begin
         ot_hold_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crowbar_q <= 1'b0;
      end else if (clr) begin
         crowbar_q <= 1'b0;
      end else if (fb_ov_i && (monitor || flt_ov_q)) begin
         crowbar_q <= 1'b1;
      end else if (fb_ovrel_i) begin
         crowbar_q <= 1'b0;
      end
   end

   assign pwm_en_o   = en_i && !vcc_low_i && monitor && !ot_hold_q;
   assign lg_force_o = crowbar_q;
   assign pg_code_o  = pg_code;

   // R10: dropping enable stops switching within the same cycle
   assert_pwm_off_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !pwm_en_o);
   // R10: a latched over-current survives while enable and supply hold
   assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_oc_q && en_i && !vcc_low_i) |=> flt_oc_q);
   // R7: the crowbar is only ever requested with an over-voltage latched
   assert_crowbar_needs_ov_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lg_force_o |-> flt_ov_q);
   // R12: a tripped converter never switches
   assert_trip_stops_pwm_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TRIP) |-> !pwm_en_o);
   // R2: entering the ramp requires the arm to have been set
   assert_start_needs_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RAMP && $past(state_q) == ST_OFF) |-> $past(armed_q));

endmodule

// File: tb/buck_fault_supervisor_bench.sv
module buck_fault_supervisor_bench;
   localparam int REF_W = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_i = 0, vcc_ok_i = 0, vcc_low_i = 0, tick_i = 0, pulse_i = 0;
   logic oc_i = 0, sc_i = 0, fb_ov_i = 0, fb_ovrel_i = 0, fb_uv_i = 0;
   logic ot_hot_i = 0, ot_cool_i = 0;
   logic [REF_W-1:0] ss_ref_o;
   logic pwm_en_o, lg_force_o;
   logic [1:0] pg_code_o;
   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   buck_fault_supervisor u_buck_fault_supervisor (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .vcc_ok_i(vcc_ok_i), .vcc_low_i(vcc_low_i),
      .tick_i(tick_i), .pulse_i(pulse_i), .oc_i(oc_i), .sc_i(sc_i),
      .fb_ov_i(fb_ov_i), .fb_ovrel_i(fb_ovrel_i), .fb_uv_i(fb_uv_i),
      .ot_hot_i(ot_hot_i), .ot_cool_i(ot_cool_i),
      .ss_ref_o(ss_ref_o), .pwm_en_o(pwm_en_o), .lg_force_o(lg_force_o),
      .pg_code_o(pg_code_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tk(input int n);
      repeat (n) begin
         @(negedge clk) tick_i = 1'b1;
         @(negedge clk) tick_i = 1'b0;
      end
   endtask

   task automatic pls(input logic oc, input logic sc);
      @(negedge clk) begin pulse_i = 1'b1; oc_i = oc; sc_i = sc; end
      @(negedge clk) begin pulse_i = 1'b0; oc_i = 1'b0; sc_i = 1'b0; end
   endtask

   task automatic bring_up;
      @(negedge clk) begin en_i = 0; vcc_low_i = 1; vcc_ok_i = 0; end
      idle(2);
      @(negedge clk) begin vcc_low_i = 0; vcc_ok_i = 1; en_i = 1; end
      idle(2);
      tk(2750);
      idle(2);
   endtask

   task automatic t_reset;
      chk("R1 pwm", pwm_en_o, 0);
      chk("R1 ref", ss_ref_o, 0);
      chk("R1 pg", pg_code_o, 0);
      chk("R1 lg", lg_force_o, 0);
   endtask

   task automatic t_ramp;
      @(negedge clk) begin vcc_ok_i = 1; en_i = 1; end
      idle(2);
      chk("R4 pg weak in ramp", pg_code_o, 1);
      chk("R3 pwm in ramp", pwm_en_o, 1);
      chk("R3 ref start", ss_ref_o, 0);
      tk(50);
      chk("R3 ref after 50 ticks", ss_ref_o, 10);
      @(negedge clk) fb_uv_i = 1;
      idle(2);
      chk("R8 uv ignored in ramp", pwm_en_o, 1);
      @(negedge clk) fb_uv_i = 0;
      tk(1450);
      chk("R3 ref full", ss_ref_o, 300);
      idle(2);
      tk(1249);
      chk("R4 pg before release", pg_code_o, 1);
      tk(1);
      chk("R4 pg released", pg_code_o, 0);
      chk("R3 ref holds", ss_ref_o, 300);
   endtask

   task automatic t_en_low;
      @(negedge clk) en_i = 0;
      #1;
      chk("R10 pwm off same cycle", pwm_en_o, 0);
      chk("R10 pg open same cycle", pg_code_o, 0);
      idle(2);
      chk("R10 ref cleared", ss_ref_o, 0);
   endtask

   task automatic t_no_rearm;
      @(negedge clk) en_i = 1;
      idle(3);
      chk("R2 no start without arm", pwm_en_o, 0);
      chk("R2 ref idle", ss_ref_o, 0);
      chk("R4 pg weak while waiting", pg_code_o, 1);
      @(negedge clk) begin vcc_low_i = 1; vcc_ok_i = 0; end
      idle(2);
      @(negedge clk) begin vcc_low_i = 0; vcc_ok_i = 1; end
      idle(2);
      chk("R2 start after arm", pwm_en_o, 1);
      @(negedge clk) en_i = 0;
      idle(1);
   endtask

   task automatic t_oc;
      bring_up();
      pls(1, 0);
      tk(15);
      pls(0, 0);
      pls(1, 0);
      tk(19);
      chk("R5 run restarted", pg_code_o, 0);
      tk(1);
      chk("R5 oc latched", pg_code_o, 3);
      idle(1);
      chk("R12 pwm off after fault", pwm_en_o, 0);
      chk("R12 no crowbar for oc", lg_force_o, 0);
      tk(20);
      pls(0, 0);
      idle(5);
      chk("R10 fault persists", pg_code_o, 3);
   endtask

   task automatic t_sc;
      bring_up();
      pls(0, 1);
      tk(10);
      pls(0, 1);
      chk("R6 gap of 10 no trip", pg_code_o, 0);
      tk(3);
      pls(0, 1);
      chk("R6 sc latched", pg_code_o, 3);
   endtask

   task automatic t_ov;
      bring_up();
      @(negedge clk) fb_ov_i = 1;
      @(negedge clk) fb_ov_i = 0;
      chk("R7 ov code", pg_code_o, 2);
      chk("R7 crowbar on", lg_force_o, 1);
      idle(3);
      chk("R7 pwm off", pwm_en_o, 0);
      chk("R7 crowbar held", lg_force_o, 1);
      @(negedge clk) fb_ovrel_i = 1;
      @(negedge clk) fb_ovrel_i = 0;
      chk("R7 crowbar released", lg_force_o, 0);
      @(negedge clk) fb_ov_i = 1;
      @(negedge clk) fb_ov_i = 0;
      chk("R7 crowbar again", lg_force_o, 1);
      chk("R7 code kept", pg_code_o, 2);
   endtask

   task automatic t_uv;
      bring_up();
      @(negedge clk) fb_uv_i = 1;
      @(negedge clk) fb_uv_i = 0;
      chk("R8 uv code", pg_code_o, 1);
      idle(1);
      chk("R8 pwm off", pwm_en_o, 0);
   endtask

   task automatic t_ot;
      bring_up();
      @(negedge clk) ot_hot_i = 1;
      @(negedge clk) ot_hot_i = 0;
      chk("R9 pwm held off", pwm_en_o, 0);
      chk("R9 pg untouched", pg_code_o, 0);
      idle(3);
      chk("R9 still off", pwm_en_o, 0);
      @(negedge clk) ot_cool_i = 1;
      @(negedge clk) ot_cool_i = 0;
      chk("R9 resumes", pwm_en_o, 1);
   endtask

   task automatic t_prio;
      bring_up();
      pls(1, 0);
      tk(19);
      @(negedge clk) begin tick_i = 1; fb_ov_i = 1; fb_uv_i = 1; end
      @(negedge clk) begin tick_i = 0; fb_ov_i = 0; fb_uv_i = 0; end
      chk("R11 oc over ov and uv", pg_code_o, 3);
      bring_up();
      @(negedge clk) begin fb_ov_i = 1; fb_uv_i = 1; end
      @(negedge clk) begin fb_ov_i = 0; fb_uv_i = 0; end
      chk("R11 ov over uv", pg_code_o, 2);
   endtask

   initial begin
      idle(3);
      @(negedge clk) rst_n = 1;
      idle(1);
      t_reset();
      t_ramp();
      t_en_low();
      t_no_rearm();
      t_oc();
      t_sc();
      t_ov();
      t_uv();
      t_ot();
      t_prio();
      @(negedge clk) en_i = 0;
      idle(2);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(4 * 190000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule